// File: doc/BRIEF.md
# VPW Bus Symbol Decoder

This block turns the raw level of a variable-pulse-width serial bus into a stream of decoded symbols. The bus alternates between an active and a passive level. A bit's value depends on two things: the level it was sent on and how long that level lasted. The same duration on the two levels gives opposite bits. Long active periods mark the start of a frame or a break, and long passive periods mark the end of data, the end of a frame and the gap between frames.

The bus input is brought into the clock domain by a two-stage synchronizer. A divider makes a one-microsecond time base from the system clock. Every level is timed in whole microseconds from the edge that began it, and the divider restarts on each edge. Intervals are classified when the next edge arrives. Break, end-of-data, end-of-frame and inter-frame separation are reported as soon as the running length of the level crosses their threshold, so none of them needs a further edge. Each result comes out as a one-cycle strobe with a 3-bit symbol code and, for data symbols, the bit value. Byte assembly, error checking and arbitration live in downstream blocks.

Top module: `vpw_symbol_decoder`

## Requirements
- R1: A passive interval of 34 to 96 µs gives a data symbol (code 0) with bit 0. A passive interval of 97 to 163 µs gives a data symbol with bit 1. Both apply only inside a frame.
- R2: An active interval of 34 to 96 µs gives a data symbol with bit 1. An active interval of 97 to 163 µs gives a data symbol with bit 0. Both apply only inside a frame.
- R3: An active interval of 164 to 239 µs gives start-of-frame (code 1) in any state and opens a frame.
- R4: An active level that reaches 240 µs gives break (code 5) while the level is still active, exactly once per level. The decoder then returns to idle, and data is ignored until the next start-of-frame.
- R5: Inside a frame, a passive level that reaches 164 µs gives end-of-data (code 2) once. Data bits that follow it (the in-frame response) are still decoded.
- R6: If the passive level that produced end-of-data continues to 280 µs, end-of-frame (code 3) is given. If it then continues to 300 µs, inter-frame separation (code 4) is given and the decoder returns to idle.
- R7: Data-length intervals seen outside a frame produce no strobe.
- R8: Any interval shorter than 34 µs gives invalid (code 6) and returns the decoder to idle.
- R9: Each strobe lasts one clock cycle, and the bit output is 0 on every non-data strobe.
- R10: During and right after reset there is no strobe, and the code output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | 1 | Asynchronous bus level; the active level is set by a parameter (default 1) |
| sym_valid | output | 1 | One-cycle strobe for a decoded symbol |
| sym_code | output | 3 | Symbol code: 0 data, 1 start-of-frame, 2 end-of-data, 3 end-of-frame, 4 inter-frame separation, 5 break, 6 invalid |
| sym_bit | output | 1 | Bit value for data symbols, otherwise 0 |

## Verification
A wrong frame state shows up at the ports as data strobes appearing or disappearing. Data sent before any start-of-frame, or after a break or an invalid interval, would be strobed. Bits after end-of-data would be lost. In each case the error is visible on the first data interval after the bad transition. A wrong edge restart or a bad time base shifts the window limits. The bench drives intervals exactly on both sides of every limit, so a one-microsecond shift changes the code or bit of that very strobe. A wrong timeout sequence shows up as a missing, doubled or out-of-order end-of-data, end-of-frame or separation strobe in the long passive tail. That tail ends 300 µs after the last edge.

// File: rtl/vpw_dec_pkg.sv
// Shared types for the VPW symbol decoder: symbol codes and frame states.
package vpw_dec_pkg;
    typedef enum logic [2:0] {
        SYM_DATA    = 3'd0,
        SYM_SOF     = 3'd1,
        SYM_EOD     = 3'd2,
        SYM_EOF     = 3'd3,
        SYM_IFS     = 3'd4,
        SYM_BREAK   = 3'd5,
        SYM_INVALID = 3'd6
    } sym_code_e;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,   // waiting for start-of-frame
        FR_BODY  = 2'd1,   // inside frame, before end-of-data
        FR_TAIL  = 2'd2,   // after end-of-data, response bits allowed
        FR_ENDED = 2'd3    // end-of-frame given, separation pending
    } frame_st_e;
endpackage

// File: rtl/vpw_rx_sync.sv
// Brings the asynchronous bus level into the clock domain and detects edges.
// Assumes: bus_in is level-stable for at least three clock cycles around an edge.
// Output lvl_active is the level that held up to this cycle; on an edge cycle it
// is still the level that just ended.
module vpw_rx_sync #(
    parameter logic ACTIVE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    output logic edge_det,
    output logic lvl_active
);
    logic meta_q, sync_q, lvl_q;

    // Two-stage synchronizer followed by a level register, all reset to passive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= ~ACTIVE_LVL;
            sync_q <= ~ACTIVE_LVL;
            lvl_q  <= ~ACTIVE_LVL;
        end else begin
            meta_q <= bus_in;
            sync_q <= meta_q;
            lvl_q  <= sync_q;
        end
    end

    // Edge whenever the synchronized level differs from the held level.
    always_comb begin
        edge_det   = sync_q ^ lvl_q;
        lvl_active = (lvl_q == ACTIVE_LVL);
    end
endmodule

// File: rtl/vpw_us_timer.sv
// Microsecond interval timer. A divider makes a one-microsecond step. On restart
// the count clears so that us_cnt equals the whole microseconds elapsed at the
// next restart. The step pulse marks the cycle in which us_cnt takes a new value.
// Assumes: CLK_PER_US >= 2. The count saturates at its maximum.
module vpw_us_timer #(
    parameter int CLK_PER_US = 200,
    parameter int CNT_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] us_cnt,
    output logic             step
);
    localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    logic [DIV_W-1:0] div_q;

    // Divide the clock and count microseconds since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            us_cnt <= '0;
            step   <= 1'b0;
        end else if (restart) begin
            div_q  <= DIV_W'(1);
            us_cnt <= '0;
            step   <= 1'b0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
            step  <= (us_cnt != CNT_MAX);
            if (us_cnt != CNT_MAX)
                us_cnt <= us_cnt + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
            step  <= 1'b0;
        end
    end
endmodule

// File: rtl/vpw_symbol_fsm.sv
// Classifies each timed level and tracks the frame state.
// Intervals are classified on the edge that ends them. Break and the passive
// tail symbols come from threshold crossings while the level is still running.
// long_done records that a break or end-of-data was already given for the
// current level, so that the edge that ends the level does not repeat it.
// Assumes: us_cnt restarts on every edge; step marks a fresh us_cnt value.
module vpw_symbol_fsm
    import vpw_dec_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int T_NOISE     = 34,
    parameter int T_SHORT_MAX = 96,
    parameter int T_LONG_MAX  = 163,
    parameter int T_SOF_MAX   = 239,
    parameter int T_EOF       = 280,
    parameter int T_IFS       = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_det,
    input  logic             lvl_active,
    input  logic [CNT_W-1:0] us_cnt,
    input  logic             step,
    output logic             sym_valid,
    output sym_code_e        sym_code,
    output logic             sym_bit,
    output frame_st_e        frame_state
);
    localparam logic [CNT_W-1:0] L_NOISE = CNT_W'(T_NOISE);
    localparam logic [CNT_W-1:0] L_SHORT = CNT_W'(T_SHORT_MAX);
    localparam logic [CNT_W-1:0] L_LONG  = CNT_W'(T_LONG_MAX);
    localparam logic [CNT_W-1:0] L_SOF   = CNT_W'(T_SOF_MAX);
    localparam logic [CNT_W-1:0] L_BRK   = CNT_W'(T_SOF_MAX + 1);
    localparam logic [CNT_W-1:0] L_EOD   = CNT_W'(T_LONG_MAX + 1);
    localparam logic [CNT_W-1:0] L_EOF   = CNT_W'(T_EOF);
    localparam logic [CNT_W-1:0] L_IFS   = CNT_W'(T_IFS);

    frame_st_e st_q, st_d;
    logic      done_q, done_d;
    logic      v_d, b_d, in_frame;
    sym_code_e c_d;

    // Next-state and symbol decision for edge-ended and threshold-crossed levels.
    always_comb begin
        st_d     = st_q;
        done_d   = done_q;
        v_d      = 1'b0;
        c_d      = SYM_DATA;
        b_d      = 1'b0;
        in_frame = (st_q == FR_BODY) || (st_q == FR_TAIL);
        if (edge_det) begin
            done_d = 1'b0;
            if (st_q == FR_ENDED)
                st_d = FR_IDLE;
            if (us_cnt < L_NOISE) begin
                v_d  = 1'b1;
                c_d  = SYM_INVALID;
                st_d = FR_IDLE;
            end else if (us_cnt <= L_SHORT) begin
                v_d = in_frame;
                b_d = in_frame && lvl_active;
            end else if (us_cnt <= L_LONG) begin
                v_d = in_frame;
                b_d = in_frame && !lvl_active;
            end else if (lvl_active) begin
                if (us_cnt <= L_SOF) begin
                    v_d  = 1'b1;
                    c_d  = SYM_SOF;
                    st_d = FR_BODY;
                end else if (!done_q) begin
                    v_d  = 1'b1;
                    c_d  = SYM_BREAK;
                    st_d = FR_IDLE;
                end
            end else if (in_frame && !done_q) begin
                v_d  = 1'b1;
                c_d  = SYM_EOD;
                st_d = FR_TAIL;
            end
        end else if (step) begin
            if (lvl_active) begin
                if (us_cnt == L_BRK) begin
                    v_d    = 1'b1;
                    c_d    = SYM_BREAK;
                    st_d   = FR_IDLE;
                    done_d = 1'b1;
                end
            end else if (us_cnt == L_EOD && in_frame) begin
                v_d    = 1'b1;
                c_d    = SYM_EOD;
                st_d   = FR_TAIL;
                done_d = 1'b1;
            end else if (us_cnt == L_EOF && st_q == FR_TAIL) begin
                v_d  = 1'b1;
                c_d  = SYM_EOF;
                st_d = FR_ENDED;
            end else if (us_cnt == L_IFS && st_q == FR_ENDED) begin
                v_d  = 1'b1;
                c_d  = SYM_IFS;
                st_d = FR_IDLE;
            end
        end
    end

    // Register frame state, per-level flag and the output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= FR_IDLE;
            done_q    <= 1'b0;
            sym_valid <= 1'b0;
            sym_code  <= SYM_DATA;
            sym_bit   <= 1'b0;
        end else begin
            st_q      <= st_d;
            done_q    <= done_d;
            sym_valid <= v_d;
            sym_code  <= c_d;
            sym_bit   <= b_d;
        end
    end

    assign frame_state = st_q;
endmodule

// File: rtl/vpw_symbol_decoder.sv
// VPW bus symbol decoder top: synchronizer, microsecond timer and classifier.
// Assumes: CLK_PER_US >= 2 and the window limits increase in the order
// noise < short < long < start-of-frame < end-of-frame < separation.
module vpw_symbol_decoder
    import vpw_dec_pkg::*;
#(
    parameter int   CLK_PER_US  = 200,
    parameter logic ACTIVE_LVL  = 1'b1,
    parameter int   T_NOISE     = 34,
    parameter int   T_SHORT_MAX = 96,
    parameter int   T_LONG_MAX  = 163,
    parameter int   T_SOF_MAX   = 239,
    parameter int   T_EOF       = 280,
    parameter int   T_IFS       = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_in,
    output logic       sym_valid,
    output logic [2:0] sym_code,
    output logic       sym_bit
);
    localparam int CNT_W = $clog2(T_IFS + 2);

    logic             edge_det, lvl_active, step;
    logic [CNT_W-1:0] us_cnt;
    sym_code_e        code_w;
    frame_st_e        frame_state;

    vpw_rx_sync #(.ACTIVE_LVL(ACTIVE_LVL)) u_sync (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
        .edge_det(edge_det), .lvl_active(lvl_active)
    );

    vpw_us_timer #(.CLK_PER_US(CLK_PER_US), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(edge_det),
        .us_cnt(us_cnt), .step(step)
    );

    vpw_symbol_fsm #(
        .CNT_W(CNT_W), .T_NOISE(T_NOISE), .T_SHORT_MAX(T_SHORT_MAX),
        .T_LONG_MAX(T_LONG_MAX), .T_SOF_MAX(T_SOF_MAX),
        .T_EOF(T_EOF), .T_IFS(T_IFS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .edge_det(edge_det), .lvl_active(lvl_active),
        .us_cnt(us_cnt), .step(step), .sym_valid(sym_valid),
        .sym_code(code_w), .sym_bit(sym_bit), .frame_state(frame_state)
    );

    assign sym_code = code_w;
endmodule

// File: rtl/vpw_decoder_chk.sv
// Property checker for the VPW symbol decoder, bound to the top module.
module vpw_decoder_chk
    import vpw_dec_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sym_valid,
    input logic [2:0] sym_code,
    input logic       sym_bit,
    input logic       lvl_active,
    input frame_st_e  frame_state
);
    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sym_valid);

    // R9
    bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_code != SYM_DATA) |-> !sym_bit);

    // R7
    data_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_code == SYM_DATA) |->
        ($past(frame_state) == FR_BODY || $past(frame_state) == FR_TAIL));

    // R3
    sof_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_code == SYM_SOF) |-> frame_state == FR_BODY);

    // R4
    break_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_code == SYM_BREAK) |->
        ($past(lvl_active) && frame_state == FR_IDLE));

    // R5
    eod_passive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_code == SYM_EOD) |->
        (!$past(lvl_active) && frame_state == FR_TAIL));

    // R6
    eof_after_eod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_code == SYM_EOF) |-> $past(frame_state) == FR_TAIL);

    // R6
    ifs_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_code == SYM_IFS) |-> $past(frame_state) == FR_ENDED);

    // R8
    invalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_code == SYM_INVALID) |-> frame_state == FR_IDLE);
endmodule

bind vpw_symbol_decoder vpw_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_code(sym_code),
    .sym_bit(sym_bit), .lvl_active(lvl_active), .frame_state(frame_state)
);

// File: tb/vpw_symbol_decoder_bench.sv
// Scoreboard bench: the driver pushes the expected symbols, the monitor compares.
module vpw_symbol_decoder_bench;
    localparam int CPU = 4;
    localparam logic [2:0] C_DATA = 3'd0, C_SOF = 3'd1, C_EOD = 3'd2, C_EOF = 3'd3,
                           C_IFS = 3'd4, C_BRK = 3'd5, C_INV = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_in = 1'b0;
    logic sym_valid, sym_bit;
    logic [2:0] sym_code;

    int n_checks = 0;
    int n_fail = 0;
    logic [2:0] q_code[$];
    logic       q_bit[$];
    string      q_req[$];

    always #2.5 clk = ~clk;

    vpw_symbol_decoder #(.CLK_PER_US(CPU)) u_vpw_symbol_decoder (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
        .sym_valid(sym_valid), .sym_code(sym_code), .sym_bit(sym_bit)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_sym(input logic [2:0] c, input logic b, input string req);
        q_code.push_back(c);
        q_bit.push_back(b);
        q_req.push_back(req);
    endtask

    // Hold the bus at a level for a number of microseconds.
    task automatic hold(input logic lvl, input int us);
        bus_in = lvl;
        repeat (us * CPU) @(negedge clk);
    endtask

    // Monitor: pop and compare on every strobe.
    always @(negedge clk) begin
        if (rst_n && sym_valid) begin
            if (q_code.size() == 0) begin
                check(1'b0, "R7", "unexpected strobe code", int'(sym_code), -1);
            end else begin
                check(sym_code == q_code[0], q_req[0], "code", int'(sym_code), int'(q_code[0]));
                check(sym_bit == q_bit[0], q_req[0], "bit", int'(sym_bit), int'(q_bit[0]));
                void'(q_code.pop_front());
                void'(q_bit.pop_front());
                void'(q_req.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        check(sym_valid == 1'b0, "R10", "valid in reset", int'(sym_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sym_valid == 1'b0, "R10", "valid after reset", int'(sym_valid), 0);
        check(sym_code == C_DATA, "R10", "code after reset", int'(sym_code), 0);
        hold(1'b0, 400);
        // R7: data-length levels before any start-of-frame are ignored
        hold(1'b1, 64); hold(1'b0, 64); hold(1'b1, 128); hold(1'b0, 400);
        // Frame with data, end-of-data, response bits and full tail
        expect_sym(C_SOF, 1'b0, "R3");  hold(1'b1, 200);
        expect_sym(C_DATA, 1'b1, "R1"); hold(1'b0, 128);
        expect_sym(C_DATA, 1'b1, "R2"); hold(1'b1, 64);
        expect_sym(C_DATA, 1'b0, "R1"); hold(1'b0, 64);
        expect_sym(C_DATA, 1'b0, "R2"); hold(1'b1, 128);
        expect_sym(C_EOD, 1'b0, "R5");  hold(1'b0, 200);
        expect_sym(C_DATA, 1'b1, "R5"); hold(1'b1, 64);
        expect_sym(C_DATA, 1'b1, "R5"); hold(1'b0, 128);
        expect_sym(C_DATA, 1'b0, "R5"); hold(1'b1, 128);
        expect_sym(C_EOD, 1'b0, "R5");
        expect_sym(C_EOF, 1'b0, "R6");
        expect_sym(C_IFS, 1'b0, "R6");  hold(1'b0, 320);
        // R4: break mid-frame, then data is ignored
        expect_sym(C_SOF, 1'b0, "R3");  hold(1'b1, 200);
        expect_sym(C_DATA, 1'b0, "R1"); hold(1'b0, 64);
        expect_sym(C_BRK, 1'b0, "R4");  hold(1'b1, 300);
        hold(1'b0, 64); hold(1'b1, 64); hold(1'b0, 400);
        // Window limits, noise reject and start-of-frame limits
        expect_sym(C_SOF, 1'b0, "R3");  hold(1'b1, 200);
        expect_sym(C_DATA, 1'b0, "R1"); hold(1'b0, 96);
        expect_sym(C_DATA, 1'b1, "R2"); hold(1'b1, 96);
        expect_sym(C_DATA, 1'b1, "R1"); hold(1'b0, 97);
        expect_sym(C_DATA, 1'b0, "R2"); hold(1'b1, 97);
        expect_sym(C_DATA, 1'b1, "R1"); hold(1'b0, 163);
        expect_sym(C_DATA, 1'b0, "R2"); hold(1'b1, 163);
        expect_sym(C_DATA, 1'b0, "R1"); hold(1'b0, 34);
        expect_sym(C_DATA, 1'b1, "R2"); hold(1'b1, 34);
        expect_sym(C_INV, 1'b0, "R8");  hold(1'b0, 33);
        hold(1'b1, 64); hold(1'b0, 400);
        expect_sym(C_SOF, 1'b0, "R3");  hold(1'b1, 164);
        expect_sym(C_DATA, 1'b0, "R1"); hold(1'b0, 64);
        expect_sym(C_SOF, 1'b0, "R3");  hold(1'b1, 239);
        expect_sym(C_EOD, 1'b0, "R5");
        expect_sym(C_EOF, 1'b0, "R6");
        expect_sym(C_IFS, 1'b0, "R6");  hold(1'b0, 400);
        hold(1'b1, 64); hold(1'b0, 100);
        check(q_code.size() == 0, "R7", "missing strobes", q_code.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule